// File: doc/BRIEF.md
# Buffered 2x2 Switching Element

This block is one 2x2 switching element of a banyan-style multistage packet network. The network runs in time slots, and one clock cycle is one slot. In each slot either input may offer one fixed-length packet. A packet is represented by its routing tag. The stage index selects one bit of that tag, and the bit steers the packet through a small crossbar into one of two private FIFO output queues, one per output link. The packet at the head of each queue is offered downstream. If the next element signals that it is full, the head packet either waits for a later slot or is thrown away, depending on a mode input.

When both inputs want the one remaining place in the same queue, a policy input decides which input wins:
- a fair coin taken from an on-chip LFSR, or
- the input whose upstream queue holds more packets, with the coin used when the two counts are equal.

Each queue keeps three counters: packets forwarded, blocking events, and accumulated waiting (queue occupancy summed slot by slot).

Top module: `swe_top`

## Requirements
- R1: A packet is routed by bit STAGE of its tag. A value of 0 enqueues it on output 0 (upper) and 1 enqueues it on output 1 (lower).
- R2: Each queue is first-in first-out. `outValid[q]` is high exactly when queue q is non-empty, and `outTag[q]` is the oldest packet it holds.
- R3: `outOcc[q]` equals the number of packets in queue q and never exceeds DEPTH.
- R4: When `outValid[q]` and `downRdy[q]` are both high at a clock edge, the head packet leaves and the serviced counter of queue q grows by one.
- R5: When `outValid[q]` is high and `downRdy[q]` is low, the blocked counter of queue q grows by one. With `dropMode` low, the head packet stays at the head.
- R6: With `dropMode` high, a blocked head packet is discarded in that slot.
- R7: The free room of queue q in a slot is DEPTH minus its occupancy, plus one if its head leaves (forwarded or dropped) in that slot. Inputs are accepted while room lasts. When both are accepted into one queue, the packet from input 0 is placed ahead. `inAccept[i]` is never high without `inValid[i]`.
- R8: With `prioMode` low, when both inputs target one queue with exactly one free place, input 0 wins if bit 0 of the LFSR is 0, and input 1 wins otherwise. The loser's `inAccept` stays low.
- R9: With `prioMode` high in the same situation, the input with the larger `inOcc` wins. Equal values fall back to the rule of R8.
- R10: The LFSR is 16 bits wide. During reset it loads `seed`, or 1 when `seed` is 0. In every slot after reset it shifts left, taking in the XOR of bits 15, 13, 12 and 10 as its new bit 0.
- R11: In every slot, the delay counter of queue q adds the occupancy of q minus one if its head left in that slot.
- R12: After a synchronous reset both queues are empty and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| seed | input | 16 | LFSR seed loaded during reset |
| dropMode | input | 1 | 1: blocked head packet is discarded; 0: it is held |
| prioMode | input | 1 | 1: occupancy-based contention; 0: coin only |
| inValid | input | 2 | Packet offered on each input |
| inTag | input | 2 x ADDR_W | Routing tag per input |
| inOcc | input | 2 x OCC_W | Occupancy of the sending queue per input |
| inAccept | output | 2 | Input packet taken this slot |
| outValid | output | 2 | Queue head present per output |
| outTag | output | 2 x ADDR_W | Head packet tag per output |
| outOcc | output | 2 x OCC_W | Queue occupancy per output |
| downRdy | input | 2 | Downstream element has room |
| servCnt | output | 2 x CNT_W | Forwarded packets per queue |
| blkCnt | output | 2 x CNT_W | Blocking events per queue |
| dlyCnt | output | 2 x DLY_W | Accumulated waiting per queue |

## Verification
A corrupted queue pointer or entry shows up as a wrong `outTag` or `outOcc` in the very next slot, and a lost packet shows up when its tag fails to appear in FIFO order. A wrong LFSR state or a wrong arbitration decision appears as a wrong `inAccept` in the first slot with single-place contention. A miscounted departure appears on `servCnt`, `blkCnt` or `dlyCnt` one slot later. The bench models the queues, the coin and the counters from the requirements, and compares all of them in every slot.

// File: rtl/swe_pkg.sv
package swe_pkg;
  localparam int LFSR_W = 16;

  // per-queue command word from control to datapath
  typedef struct packed {
    logic wr0;   // append input 0 packet
    logic wr1;   // append input 1 packet (behind input 0)
    logic pop;   // head leaves (forwarded or dropped)
    logic fwd;   // head forwarded downstream
    logic blk;   // head blocked this slot
  } qStrobe_t;
endpackage

// File: rtl/swe_ctrl.sv
module swe_ctrl
  import swe_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int OCC_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LFSR_W-1:0]     seed,
  input  logic                  dropMode,
  input  logic                  prioMode,
  input  logic [1:0]            inValid,
  input  logic [1:0]            inRoute,
  input  logic [1:0][OCC_W-1:0] inOcc,
  input  logic [1:0][OCC_W-1:0] qCnt,
  input  logic [1:0]            downRdy,
  output logic [1:0]            inAccept,
  output qStrobe_t [1:0]        stb
);
  localparam int SP_W = OCC_W + 1;

  logic [LFSR_W-1:0] lfsr;
  logic              lfsrFb;
  logic              firstWins;
  logic [1:0]        grant0, grant1;

  assign lfsrFb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= (seed == '0) ? LFSR_W'(1) : seed;
    else     lfsr <= {lfsr[LFSR_W-2:0], lfsrFb};
  end

  // winner of a single-place contention: 1 means input 0
  always_comb begin
    firstWins = ~lfsr[0];
    if (prioMode) begin
      if (inOcc[0] > inOcc[1])      firstWins = 1'b1;
      else if (inOcc[0] < inOcc[1]) firstWins = 1'b0;
    end
  end

  for (genvar q = 0; q < 2; q++) begin : g_q
    logic            headV, fwdQ, blkQ, leaveQ, want0, want1, g0, g1;
    logic [SP_W-1:0] space;

    assign headV  = qCnt[q] != '0;
    assign fwdQ   = headV & downRdy[q];
    assign blkQ   = headV & ~downRdy[q];
    assign leaveQ = fwdQ | (blkQ & dropMode);
    assign space  = SP_W'(DEPTH) - {1'b0, qCnt[q]} + {{OCC_W{1'b0}}, leaveQ};
    assign want0  = inValid[0] & (inRoute[0] == 1'(q));
    assign want1  = inValid[1] & (inRoute[1] == 1'(q));

    always_comb begin
      g0 = 1'b0;
      g1 = 1'b0;
      if (want0 && want1) begin
        if (space >= SP_W'(2)) begin
          g0 = 1'b1;
          g1 = 1'b1;
        end else if (space == SP_W'(1)) begin
          g0 = firstWins;
          g1 = ~firstWins;
        end
      end else begin
        g0 = want0 && (space != '0);
        g1 = want1 && (space != '0);
      end
    end

    assign grant0[q] = g0;
    assign grant1[q] = g1;
    assign stb[q]    = '{wr0: g0, wr1: g1, pop: leaveQ, fwd: fwdQ, blk: blkQ};
  end

  assign inAccept[0] = |grant0;
  assign inAccept[1] = |grant1;
endmodule

// File: rtl/swe_queue.sv
module swe_queue
  import swe_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 4,
  parameter int OCC_W  = 2,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  qStrobe_t          stb,
  input  logic [ADDR_W-1:0] tag0,
  input  logic [ADDR_W-1:0] tag1,
  output logic [ADDR_W-1:0] headTag,
  output logic [OCC_W-1:0]  cnt,
  output logic [CNT_W-1:0]  servCnt,
  output logic [CNT_W-1:0]  blkCnt,
  output logic [DLY_W-1:0]  dlyCnt
);
  logic [ADDR_W-1:0] mem  [DEPTH];
  logic [ADDR_W-1:0] nMem [DEPTH];
  logic [OCC_W-1:0]  nCnt;
  logic [OCC_W-1:0]  afterPop;

  // head sits at index 0; a pop shifts everything forward
  always_comb begin
    nMem = mem;
    afterPop = cnt;
    if (stb.pop) begin
      for (int i = 0; i < DEPTH - 1; i++) nMem[i] = mem[i + 1];
      afterPop = cnt - OCC_W'(1);
    end
    nCnt = afterPop;
    if (stb.wr0) begin
      if (nCnt < OCC_W'(DEPTH)) nMem[nCnt] = tag0;
      nCnt = nCnt + OCC_W'(1);
    end
    if (stb.wr1) begin
      if (nCnt < OCC_W'(DEPTH)) nMem[nCnt] = tag1;
      nCnt = nCnt + OCC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      servCnt <= '0;
      blkCnt  <= '0;
      dlyCnt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt     <= nCnt;
      mem     <= nMem;
      servCnt <= servCnt + CNT_W'(stb.fwd);
      blkCnt  <= blkCnt + CNT_W'(stb.blk);
      dlyCnt  <= dlyCnt + DLY_W'(afterPop);
    end
  end

  assign headTag = mem[0];
endmodule

// File: rtl/swe_top.sv
module swe_top
  import swe_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 4,
  parameter int STAGE  = 0,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 20,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LFSR_W-1:0]      seed,
  input  logic                   dropMode,
  input  logic                   prioMode,
  input  logic [1:0]             inValid,
  input  logic [1:0][ADDR_W-1:0] inTag,
  input  logic [1:0][OCC_W-1:0]  inOcc,
  output logic [1:0]             inAccept,
  output logic [1:0]             outValid,
  output logic [1:0][ADDR_W-1:0] outTag,
  output logic [1:0][OCC_W-1:0]  outOcc,
  input  logic [1:0]             downRdy,
  output logic [1:0][CNT_W-1:0]  servCnt,
  output logic [1:0][CNT_W-1:0]  blkCnt,
  output logic [1:0][DLY_W-1:0]  dlyCnt
);
  qStrobe_t [1:0]        stb;
  logic [1:0]            inRoute;
  logic [1:0][OCC_W-1:0] qCnt;

  assign inRoute = {inTag[1][STAGE], inTag[0][STAGE]};

  swe_ctrl #(.DEPTH(DEPTH), .OCC_W(OCC_W)) ctrl_i (
    .clk(clk), .rst(rst), .seed(seed), .dropMode(dropMode), .prioMode(prioMode),
    .inValid(inValid), .inRoute(inRoute), .inOcc(inOcc), .qCnt(qCnt),
    .downRdy(downRdy), .inAccept(inAccept), .stb(stb)
  );

  for (genvar q = 0; q < 2; q++) begin : g_out
    swe_queue #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OCC_W(OCC_W), .CNT_W(CNT_W), .DLY_W(DLY_W)
    ) queue_i (
      .clk(clk), .rst(rst), .stb(stb[q]), .tag0(inTag[0]), .tag1(inTag[1]),
      .headTag(outTag[q]), .cnt(qCnt[q]), .servCnt(servCnt[q]),
      .blkCnt(blkCnt[q]), .dlyCnt(dlyCnt[q])
    );
    assign outValid[q] = qCnt[q] != '0;
  end

  assign outOcc = qCnt;
endmodule

// File: rtl/swe_chk.sv
module swe_chk #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int OCC_W  = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   dropMode,
  input logic [1:0]             inValid,
  input logic [1:0]             inAccept,
  input logic [1:0]             outValid,
  input logic [1:0][ADDR_W-1:0] outTag,
  input logic [1:0][OCC_W-1:0]  outOcc,
  input logic [1:0]             downRdy,
  input logic [1:0][CNT_W-1:0]  servCnt,
  input logic [1:0][CNT_W-1:0]  blkCnt
);
  for (genvar q = 0; q < 2; q++) begin : g_a
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      outOcc[q] <= OCC_W'(DEPTH));
    // R7
    accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
      inAccept[q] |-> inValid[q]);
    // R4
    serv_count_chk: assert property (@(posedge clk) disable iff (rst)
      (outValid[q] && downRdy[q]) |=> servCnt[q] == $past(servCnt[q]) + CNT_W'(1));
    // R5
    blk_count_chk: assert property (@(posedge clk) disable iff (rst)
      (outValid[q] && !downRdy[q]) |=> blkCnt[q] == $past(blkCnt[q]) + CNT_W'(1));
    // R5
    hold_head_chk: assert property (@(posedge clk) disable iff (rst)
      (!dropMode && outValid[q] && !downRdy[q]) |=> (outValid[q] && outTag[q] == $past(outTag[q])));
    // R12
    reset_empty_chk: assert property (@(posedge clk)
      rst |=> (!outValid[q] && servCnt[q] == '0 && blkCnt[q] == '0));
  end
endmodule

bind swe_top swe_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OCC_W(OCC_W)) chk_i (
  .clk(clk), .rst(rst), .dropMode(dropMode), .inValid(inValid), .inAccept(inAccept),
  .outValid(outValid), .outTag(outTag), .outOcc(outOcc), .downRdy(downRdy),
  .servCnt(servCnt), .blkCnt(blkCnt)
);

// File: tb/swe_top_tb_top.sv
`timescale 1ns/1ps
module swe_top_tb_top;
  localparam int DEPTH = 2, ADDR_W = 4, STAGE = 1, CNT_W = 16, DLY_W = 20, OCC_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] seed = 16'hACE1;
  logic dropMode = 1'b0, prioMode = 1'b0;
  logic [1:0] inValid = '0, inAccept, outValid, downRdy = '0;
  logic [1:0][ADDR_W-1:0] inTag = '0, outTag;
  logic [1:0][OCC_W-1:0] inOcc = '0, outOcc;
  logic [1:0][CNT_W-1:0] servCnt, blkCnt;
  logic [1:0][DLY_W-1:0] dlyCnt;

  always #4 clk = ~clk;

  swe_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .STAGE(STAGE), .CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst(rst), .seed(seed), .dropMode(dropMode), .prioMode(prioMode),
    .inValid(inValid), .inTag(inTag), .inOcc(inOcc), .inAccept(inAccept),
    .outValid(outValid), .outTag(outTag), .outOcc(outOcc), .downRdy(downRdy),
    .servCnt(servCnt), .blkCnt(blkCnt), .dlyCnt(dlyCnt)
  );

  int nChk = 0, nErr = 0;
  int mq [2][$];            // scoreboard: expected packets per queue
  int mServ[2], mBlk[2], mDly[2];
  logic [15:0] st;          // LFSR model
  bit seedZeroPhase = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [15:0] s);
    @(negedge clk);
    rst = 1'b1; seed = s; inValid = '0; downRdy = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int q = 0; q < 2; q++) begin
      mq[q].delete(); mServ[q] = 0; mBlk[q] = 0; mDly[q] = 0;
    end
    st = (s == 16'h0) ? 16'h1 : s;
    #1;
    for (int q = 0; q < 2; q++) begin  // R12
      chk("R12", "outValid", int'(outValid[q]), 0);
      chk("R12", "outOcc", int'(outOcc[q]), 0);
      chk("R12", "dlyCnt", int'(dlyCnt[q]), 0);
    end
  endtask

  // driver + reference; called right after a falling edge, returns at the next one
  task automatic step(input bit v0, input logic [3:0] t0, input int o0,
                      input bit v1, input logic [3:0] t1, input int o1,
                      input bit r0, input bit r1);
    int c[2]; bit f[2], b[2], lv[2], w0[2], w1[2], g0[2], g1[2];
    int sp; bit first; string areq;
    inValid = {v1, v0}; inTag[0] = t0; inTag[1] = t1;
    inOcc[0] = OCC_W'(o0); inOcc[1] = OCC_W'(o1); downRdy = {r1, r0};
    #1;
    first = (st[0] == 1'b0);
    if (prioMode && o0 > o1) first = 1;
    if (prioMode && o0 < o1) first = 0;
    areq = "R7";
    for (int q = 0; q < 2; q++) begin
      c[q] = mq[q].size();
      chk("R2", "outValid", int'(outValid[q]), int'(c[q] > 0));
      chk(dropMode ? "R6" : "R3", "outOcc", int'(outOcc[q]), c[q]);
      if (c[q] > 0) chk("R2", "outTag", int'(outTag[q]), mq[q][0]);
      chk("R4", "servCnt", int'(servCnt[q]), mServ[q]);
      chk("R5", "blkCnt", int'(blkCnt[q]), mBlk[q]);
      chk("R11", "dlyCnt", int'(dlyCnt[q]), mDly[q]);
      f[q] = (c[q] > 0) && (q == 0 ? r0 : r1);
      b[q] = (c[q] > 0) && !(q == 0 ? r0 : r1);
      lv[q] = f[q] || (b[q] && dropMode);
      sp = DEPTH - c[q] + int'(lv[q]);
      w0[q] = v0 && (int'(t0[STAGE]) == q);
      w1[q] = v1 && (int'(t1[STAGE]) == q);
      g0[q] = 0; g1[q] = 0;
      if (w0[q] && w1[q]) begin
        if (sp >= 2) begin g0[q] = 1; g1[q] = 1; end
        else if (sp == 1) begin
          g0[q] = first; g1[q] = !first;
          areq = (prioMode && o0 != o1) ? "R9" : (seedZeroPhase ? "R10" : "R8");
        end
      end else begin
        g0[q] = w0[q] && sp > 0;
        g1[q] = w1[q] && sp > 0;
      end
    end
    chk(areq, "inAccept0", int'(inAccept[0]), int'(g0[0] | g0[1]));
    chk(areq, "inAccept1", int'(inAccept[1]), int'(g1[0] | g1[1]));
    for (int q = 0; q < 2; q++) begin
      if (lv[q]) void'(mq[q].pop_front());
      mDly[q] += c[q] - int'(lv[q]);
      mServ[q] += int'(f[q]);
      mBlk[q] += int'(b[q]);
      if (g0[q]) mq[q].push_back(int'(t0));
      if (g1[q]) mq[q].push_back(int'(t1));
    end
    st = {st[14:0], st[15] ^ st[13] ^ st[12] ^ st[10]};
    @(negedge clk);
  endtask

  task automatic randPhase(input int n, input int rdyPct);
    for (int k = 0; k < n; k++)
      step(1'($urandom), 4'($urandom), int'($urandom % 3), 1'($urandom), 4'($urandom),
           int'($urandom % 3), ($urandom % 100) < rdyPct, ($urandom % 100) < rdyPct);
  endtask

  initial begin
    #(8 * 100000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    doReset(16'hACE1);
    // R1: bit STAGE=1 steers to the lower queue, 0 to the upper one
    step(1, 4'b0010, 0, 0, 4'b0000, 0, 0, 0);
    #1 chk("R1", "lower queue after tag bit1=1", int'(outValid), 2);
    step(0, 4'b0000, 0, 1, 4'b1101, 0, 0, 0);
    #1 chk("R1", "upper queue after tag bit1=0", int'(outValid), 3);
    // fill lower queue then contend both for its last place
    step(1, 4'b0110, 2, 1, 4'b0011, 1, 0, 0);
    randPhase(300, 70);
    prioMode = 1'b1; randPhase(300, 60);
    dropMode = 1'b1; randPhase(300, 50);
    prioMode = 1'b0; randPhase(200, 40);
    dropMode = 1'b0;
    seedZeroPhase = 1;
    doReset(16'h0000);                 // R10
    randPhase(200, 50);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule